// File: doc/BRIEF.md
# Floating-Point Issue Collision Gate

This block decides, one cycle at a time, whether a floating-point operation may enter a pipeline whose internal stages are shared between operation types. There are eight shared stages: unpack (U), shift (S), add (A), round (R), exception test (E), multiply first half (M), multiply second half (N) and divide (D). Each operation class has a fixed table that says which of those stages it uses in each cycle after issue.

The block keeps a map of every stage already claimed for each future cycle, up to the length of the longest table. A request is compared against that map. If no stage in any cycle is claimed twice, the request is granted in the same cycle and its table is merged into the map. If some stage would be claimed twice, the block raises a stall and adds nothing to the map. The requester keeps the same opcode on its inputs and the block checks it again on the next cycle. The map moves forward by one cycle on every clock.

The arithmetic, operand dependences and square root are handled elsewhere.

Top module: `fp_issue_gate`

## Requirements
- R1: Opcode 0 (add/subtract) uses U at offset 0, S and A at 1, A and R at 2, R and S at 3. A second add held after a granted add is stalled at offsets 1 and 2 and granted at offset 3.
- R2: Opcode 1 (multiply) uses U at 0, E and M at 1, M at 2 to 4, N at 5, N and A at 6, R at 7. A second multiply held after a granted multiply is stalled at offsets 1 to 3 and granted at offset 4.
- R3: An add first requested k cycles after a granted multiply, with nothing else in flight, is granted for k = 1, 2, 3 and 6, and stalled for k = 4 and 5.
- R4: Opcode 2 (negate/absolute) uses U at 0 and S at 1. A stream of them is granted on every cycle.
- R5: Opcode 3 (compare) uses U at 0, A at 1, R at 2. A compare requested one cycle after an add is stalled and granted on the next cycle. Back-to-back compares are both granted.
- R6: Opcode 4 (divide) uses U at 0, A at 1, R at 2, D at 3 to 29, D and A at 30 and 32, D and R at 31 and 33, A at 34, R at 35. A second divide held after a granted divide is stalled at offsets 1 to 31 and granted at offset 32.
- R7: A request is granted (issue high) exactly when it is valid, has a known opcode and claims no stage already claimed in the same cycle. Otherwise, if it is valid and known, busy is high. A stalled request claims nothing.
- R8: Opcodes 5, 6 and 7 are ignored: issue and busy stay low, and the claims made by earlier grants stay as they were.
- R9: While rst_n is low, issue and busy are low. A reset clears all claims, so the first request after reset is granted.
- R10: issue and busy are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Operation class of the request (0 add, 1 multiply, 2 negate/absolute, 3 compare, 4 divide) |
| issue | output | 1 | The request is granted this cycle |
| busy | output | 1 | The request collides with existing claims and must be retried |

## Verification
A wrong bit in the claim map appears at the ports only when a later request asks for that stage in that cycle. It then shows as a spurious stall or a spurious grant in the very cycle of that request. A map that moves by the wrong amount per clock shifts the gap pattern of a collision, for example the multiply-then-add window, and so moves the grant cycle. Driving each operation pair at every offset, and comparing issue and busy on every clock against an independent model, catches such faults in the first cycle where they differ.

// File: rtl/fp_resv_pkg.sv
package fp_resv_pkg;
  localparam int NUM_STAGES = 8;
  localparam int PAT_LEN    = 36;
  localparam int OP_W       = 3;

  // stage bit positions inside a claim mask
  localparam int ST_U = 0;
  localparam int ST_S = 1;
  localparam int ST_A = 2;
  localparam int ST_R = 3;
  localparam int ST_E = 4;
  localparam int ST_M = 5;
  localparam int ST_N = 6;
  localparam int ST_D = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_MUL = 3'd1,
    OP_NEG = 3'd2,
    OP_CMP = 3'd3,
    OP_DIV = 3'd4
  } fp_op_e;

  typedef logic [NUM_STAGES-1:0] stage_mask_t;

  function automatic stage_mask_t st(int s);
    return stage_mask_t'(1) << s;
  endfunction

  function automatic logic op_known(logic [OP_W-1:0] op);
    return op <= OP_DIV;
  endfunction

  // stages claimed by class op, k cycles after its issue
  function automatic stage_mask_t stage_use(logic [OP_W-1:0] op, int k);
    stage_mask_t m;
    m = '0;
    case (op)
      OP_ADD: begin
        if (k == 0) m = st(ST_U);
        else if (k == 1) m = st(ST_S) | st(ST_A);
        else if (k == 2) m = st(ST_A) | st(ST_R);
        else if (k == 3) m = st(ST_R) | st(ST_S);
      end
      OP_MUL: begin
        if (k == 0) m = st(ST_U);
        else if (k == 1) m = st(ST_E) | st(ST_M);
        else if (k >= 2 && k <= 4) m = st(ST_M);
        else if (k == 5) m = st(ST_N);
        else if (k == 6) m = st(ST_N) | st(ST_A);
        else if (k == 7) m = st(ST_R);
      end
      OP_NEG: begin
        if (k == 0) m = st(ST_U);
        else if (k == 1) m = st(ST_S);
      end
      OP_CMP: begin
        if (k == 0) m = st(ST_U);
        else if (k == 1) m = st(ST_A);
        else if (k == 2) m = st(ST_R);
      end
      OP_DIV: begin
        if (k == 0) m = st(ST_U);
        else if (k == 1 || k == 34) m = st(ST_A);
        else if (k == 2 || k == 35) m = st(ST_R);
        else if (k >= 3 && k <= 29) m = st(ST_D);
        else if (k == 30 || k == 32) m = st(ST_D) | st(ST_A);
        else if (k == 31 || k == 33) m = st(ST_D) | st(ST_R);
      end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/fpr_pattern.sv
module fpr_pattern
  import fp_resv_pkg::*;
#(
  parameter int DEPTH = PAT_LEN,
  parameter int NST   = NUM_STAGES
) (
  input  logic [OP_W-1:0]            op,
  output logic [DEPTH-1:0][NST-1:0]  pat
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    assign pat[i] = stage_use(op, i);
  end
endmodule

// File: rtl/fpr_collide.sv
module fpr_collide #(
  parameter int DEPTH = 36,
  parameter int NST   = 8
) (
  input  logic [DEPTH-1:0][NST-1:0] held,
  input  logic [DEPTH-1:0][NST-1:0] want,
  output logic                      hit
);
  logic [DEPTH-1:0] row_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    assign row_hit[i] = |(held[i] & want[i]);
  end

  assign hit = |row_hit;
endmodule

// File: rtl/fpr_window.sv
module fpr_window #(
  parameter int DEPTH = 36,
  parameter int NST   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [DEPTH-1:0][NST-1:0] load_pat,
  output logic [DEPTH-1:0][NST-1:0] rows
);
  // row i holds the claims for the cycle i clocks from now
  logic [DEPTH-1:0][NST-1:0] merged;

  assign merged = rows | (load ? load_pat : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) rows <= '0;
    else        rows <= merged >> NST;
  end
endmodule

// File: rtl/fp_issue_gate.sv
module fp_issue_gate
  import fp_resv_pkg::*;
#(
  parameter int DEPTH = PAT_LEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [OP_W-1:0] req_op,
  output logic            issue,
  output logic            busy
);
  localparam int NST = NUM_STAGES;

  logic [DEPTH-1:0][NST-1:0] want_rows;
  logic [DEPTH-1:0][NST-1:0] held_rows;
  logic                      known_op;
  logic                      collide;
  logic                      live_req;

  fpr_pattern #(.DEPTH(DEPTH), .NST(NST)) u_pat (
    .op  (req_op),
    .pat (want_rows)
  );

  fpr_collide #(.DEPTH(DEPTH), .NST(NST)) u_col (
    .held (held_rows),
    .want (want_rows),
    .hit  (collide)
  );

  assign known_op = op_known(req_op);
  assign live_req = rst_n & req_valid & known_op;
  assign issue    = live_req & ~collide;
  assign busy     = live_req & collide;

  fpr_window #(.DEPTH(DEPTH), .NST(NST)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue),
    .load_pat (want_rows),
    .rows     (held_rows)
  );
endmodule

// File: rtl/fp_issue_gate_chk.sv
module fp_issue_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       issue,
  input logic       busy
);
  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && busy));

  // R7
  busy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || issue) |-> req_valid);

  // R8
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op > 3'd4) |-> (!issue && !busy));

  // R1
  add_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue && req_op == 3'd0) && req_valid && req_op == 3'd0) |-> busy);

  // R2
  mul_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue && req_op == 3'd1, 3) && req_valid && req_op == 3'd1) |-> busy);

  // R3
  mul_add_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue && req_op == 3'd1, 4) && req_valid && req_op == 3'd0) |-> busy);
endmodule

bind fp_issue_gate fp_issue_gate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .issue     (issue),
  .busy      (busy)
);

// File: tb/sim_fp_issue_gate.sv
module sim_fp_issue_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic       issue, busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] occ [0:63];

  always #10 clk = ~clk;

  fp_issue_gate u0 (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
    .req_op (req_op), .issue (issue), .busy (busy)
  );

  // reference claims, written per stage as sets of offsets
  function automatic logic [7:0] ref_use(int op, int k);
    logic u, s, a, r, e, m, n, d;
    u = (op <= 4) && (k == 0);
    s = 0; a = 0; r = 0; e = 0; m = 0; n = 0; d = 0;
    case (op)
      0: begin s = (k == 1 || k == 3); a = (k == 1 || k == 2); r = (k == 2 || k == 3); end
      1: begin e = (k == 1); m = (k >= 1 && k <= 4); n = (k == 5 || k == 6);
               a = (k == 6); r = (k == 7); end
      2: s = (k == 1);
      3: begin a = (k == 1); r = (k == 2); end
      4: begin a = (k == 1 || k == 30 || k == 32 || k == 34);
               r = (k == 2 || k == 31 || k == 33 || k == 35);
               d = (k >= 3 && k <= 33); end
      default: ;
    endcase
    return {d, n, m, e, r, a, s, u};
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // want: 0 = model only, 1 = grant expected, 2 = stall expected
  task automatic step(string tag, logic v, logic [2:0] op, int want);
    logic col, ei, eb;
    @(negedge clk);
    req_valid = v;
    req_op = op;
    #5;
    col = 0;
    for (int k = 0; k < 64; k++) if ((occ[k] & ref_use(int'(op), k)) != 8'h0) col = 1;
    ei = v && (op <= 3'd4) && !col;
    eb = v && (op <= 3'd4) && col;
    check(tag, issue, ei, "issue vs model");
    check(tag, busy, eb, "busy vs model");
    if (want == 1) check(tag, issue, 1'b1, "grant");
    if (want == 2) check(tag, busy, 1'b1, "stall");
    @(posedge clk);
    #1;
    for (int k = 0; k < 63; k++)
      occ[k] = occ[k+1] | (ei ? ref_use(int'(op), k + 1) : 8'h0);
    occ[63] = 8'h0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step("idle", 1'b0, 3'd0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b1;
    req_op = 3'd0;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      #5;
      check("R9", issue, 1'b0, "issue in reset");
      check("R9", busy, 1'b0, "busy in reset");
    end
    for (int k = 0; k < 64; k++) occ[k] = 8'h0;
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) occ[k] = 8'h0;
    do_reset();
    idle(2);

    // R1 add held behind add
    step("R1", 1, 3'd0, 1);
    step("R1", 1, 3'd0, 2);
    step("R1", 1, 3'd0, 2);
    step("R1", 1, 3'd0, 1);
    idle(10);

    // R2 multiply held behind multiply
    step("R2", 1, 3'd1, 1);
    for (int i = 0; i < 3; i++) step("R2", 1, 3'd1, 2);
    step("R2", 1, 3'd1, 1);
    idle(12);

    // R3 add at each gap after a multiply
    for (int g = 1; g <= 6; g++) begin
      step("R3", 1, 3'd1, 1);
      if (g > 1) idle(g - 1);
      step("R3", 1, 3'd0, (g == 4 || g == 5) ? 2 : 1);
      idle(12);
    end

    // R4 negate stream
    for (int i = 0; i < 5; i++) step("R4", 1, 3'd2, 1);
    idle(4);

    // R5 compare behind add, then compare pair
    step("R5", 1, 3'd0, 1);
    step("R5", 1, 3'd3, 2);
    step("R5", 1, 3'd3, 1);
    idle(6);
    step("R5", 1, 3'd3, 1);
    step("R5", 1, 3'd3, 1);
    idle(6);

    // R6 divide held behind divide
    step("R6", 1, 3'd4, 1);
    for (int i = 0; i < 31; i++) step("R6", 1, 3'd4, 2);
    step("R6", 1, 3'd4, 1);
    idle(40);

    // R8 unknown opcodes ignored, earlier claims intact
    step("R8", 1, 3'd0, 1);
    step("R8", 1, 3'd5, 0);
    check("R8", issue | busy, 1'b0, "unknown op outputs");
    step("R8", 1, 3'd0, 2);
    step("R8", 1, 3'd6, 0);
    step("R8", 1, 3'd7, 0);
    step("R8", 1, 3'd0, 1);
    idle(6);

    // R7 stall claims nothing: multiply, add stalls twice then grants
    step("R7", 1, 3'd1, 1);
    idle(3);
    step("R7", 1, 3'd0, 2);
    step("R7", 1, 3'd0, 2);
    step("R7", 1, 3'd0, 1);
    step("R7", 1, 3'd2, 1);
    idle(12);

    // R9 reset clears claims of a divide in flight
    step("R9", 1, 3'd4, 1);
    idle(2);
    do_reset();
    step("R9", 1, 3'd4, 1);
    idle(40);

    // R10 mixed traffic, model compare every cycle
    for (int i = 0; i < 60; i++) step("R10", 1, 3'((i * 3) % 6), 0);
    idle(40);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule